// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Generator

This block turns a 32.768 kHz time-base enable pulse into two programmable timing outputs: a square-wave pin and a periodic flag that can be promoted to an interrupt request. A binary prescaler chain counts the time-base pulses. A 4-bit rate field picks which stage of that chain drives the outputs. A 3-bit divider field either lets the chain run, freezes it, or holds it cleared.

The host sees the block through simple strobes. One write strobe loads the rate/divider register, one loads the enable register, and one read strobe marks the read of the flag register, which clears the periodic flag. The flag rises on every rising edge of the selected stage, whatever the enables are. The interrupt request is that flag gated by its own enable. The square-wave pin follows the selected stage only while its own enable is set.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset, the rate/divider register reads 0x26 (divider field bits 6:4 = 010, rate field bits 3:0 = 0110). The enable register reads 0x00. The square-wave pin, the periodic flag and the interrupt request are all 0.
- R2: While the divider field is 010, the chain advances by one on every cycle with the time-base pulse high. For rate value n from 3 to 15, the selected stage has a period of 2^(n-1) pulses. Rate 1 gives a period of 128 pulses and rate 2 gives a period of 256 pulses. The stage starts low after the chain is cleared.
- R3: The square-wave pin equals the selected stage (50% duty) when enable register bit 3 is 1. When that bit is 0, the pin is held low.
- R4: The periodic flag sets in the cycle after each clock edge at which the selected stage rises, regardless of the enable bits. The interrupt request is 1 exactly when the flag is 1 and enable register bit 6 is 1.
- R5: A read strobe clears the periodic flag. If a set event falls in the same cycle as the read strobe, the flag stays 1.
- R6: Rate value 0 keeps the square-wave pin low and never sets the periodic flag.
- R7: Divider values 110 and 111 clear the prescaler chain and hold it at zero.
- R8: Divider values other than 010, 110 and 111 freeze the chain at its current count. The square-wave pin keeps its level and the flag is not set.
- R9: The enable register stores only bits 6 and 3, and its other bits read 0. Bit 7 of the rate/divider register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_tick | input | 1 | One-cycle time-base pulse at 32.768 kHz |
| wr_a | input | 1 | Write strobe for the rate/divider register |
| wr_b | input | 1 | Write strobe for the enable register |
| rd_c | input | 1 | Read strobe for the flag register; clears the periodic flag |
| wdata | input | 8 | Write data for both registers |
| reg_a_rd | output | 8 | Rate/divider register contents |
| reg_b_rd | output | 8 | Enable register contents |
| sqw | output | 1 | Square-wave output |
| pf | output | 1 | Periodic flag |
| irq | output | 1 | Periodic interrupt request |

## Verification
The hardest case to reach is a stage rising in exactly the cycle that carries a read strobe. At slow rates such rises are thousands of pulses apart. The directed phase therefore selects the fastest rates, drives a time-base pulse every cycle and issues a read on every cycle, so each set event coincides with a clear. It also measures the interval between flag events against the expected period. The random phase mixes divider changes into freeze and clear modes with rate changes in the middle of a period. A cycle-by-cycle model in the bench tracks every such change.

// File: rtl/rtg_pkg.sv
// Package: shared types and helpers for the periodic rate generator.
// Assumes the rate field is 4 bits wide and the chain has at least 14 stages.
package rtg_pkg;

    // Prescaler operating mode, decoded from the divider field.
    typedef enum logic [1:0] {
        CHAIN_RUN   = 2'd0,
        CHAIN_HOLD  = 2'd1,
        CHAIN_CLEAR = 2'd2
    } chain_mode_e;

    // Map the divider field to a chain mode.
    function automatic chain_mode_e decode_div(input logic [2:0] dv);
        if (dv[2:1] == 2'b11)
            return CHAIN_CLEAR;
        else if (dv == 3'b010)
            return CHAIN_RUN;
        else
            return CHAIN_HOLD;
    endfunction

    // Stage index of the chain that drives the output for a rate value.
    function automatic logic [3:0] stage_of_rate(input logic [3:0] rs);
        case (rs)
            4'd0:    return 4'd0;
            4'd1:    return 4'd6;
            4'd2:    return 4'd7;
            default: return rs - 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/rtg_prescaler.sv
// Module: rtg_prescaler
// Binary counter chain that advances on each time-base pulse in run mode.
// It keeps its value in hold mode and is forced to zero in clear mode.
// Assumes tick is a single-cycle enable synchronous to clk.
module rtg_prescaler
    import rtg_pkg::*;
#(
    parameter int unsigned CHAIN_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  chain_mode_e        mode,
    output logic [CHAIN_W-1:0] cnt
);

    // Chain register: clear, advance or keep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (mode == CHAIN_CLEAR)
            cnt <= '0;
        else if (mode == CHAIN_RUN && tick)
            cnt <= cnt + CHAIN_W'(1);
    end

endmodule

// File: rtl/rtg_rate_tap.sv
// Module: rtg_rate_tap
// Selects one chain stage from the rate field and drives it as the square
// wave. It also flags the pulse at which that stage is about to rise: the
// stage bit is 0, all lower bits are 1 and the chain advances.
// Assumes the stage index fits inside CHAIN_W.
module rtg_rate_tap
    import rtg_pkg::*;
#(
    parameter int unsigned CHAIN_W = 14,
    localparam int unsigned IDX_W = $clog2(CHAIN_W)
) (
    input  logic [CHAIN_W-1:0] cnt,
    input  logic [3:0]         rate_sel,
    input  logic               advance,
    output logic               tap,
    output logic               rise_evt
);

    logic [IDX_W-1:0]   stage;
    logic [CHAIN_W-1:0] match;
    logic               rate_on;

    // Decode the selected stage and whether a rate is chosen at all.
    always_comb begin
        stage   = IDX_W'(stage_of_rate(rate_sel));
        rate_on = (rate_sel != 4'd0);
    end

    // Per-stage term of the "about to rise" pattern.
    for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
        assign match[i] = (IDX_W'(i) < stage)  ? cnt[i]  :
                          (IDX_W'(i) == stage) ? ~cnt[i] : 1'b1;
    end

    // Output tap and edge event, both gated by a non-zero rate.
    always_comb begin
        tap      = rate_on & cnt[stage];
        rise_evt = rate_on & advance & (&match);
    end

endmodule

// File: rtl/rtg_flag.sv
// Module: rtg_flag
// Sticky periodic flag: set by an event, cleared by a host read.
// A set in the same cycle as a clear wins, so no event is dropped.
module rtg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_rd,
    output logic flag
);

    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_evt)
            flag <= 1'b1;
        else if (clr_rd)
            flag <= 1'b0;
    end

endmodule

// File: rtl/periodic_rate_gen.sv
// Module: periodic_rate_gen
// Top of the periodic interrupt / square-wave generator. It holds the
// rate/divider register and the enable register, runs the prescaler, taps
// the selected stage and keeps the periodic flag.
// Assumes host strobes are single-cycle and synchronous to clk.
module periodic_rate_gen
    import rtg_pkg::*;
#(
    parameter int unsigned CHAIN_W  = 14,
    parameter logic [2:0]  DIV_RST  = 3'b010,
    parameter logic [3:0]  RATE_RST = 4'b0110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tb_tick,
    input  logic       wr_a,
    input  logic       wr_b,
    input  logic       rd_c,
    input  logic [7:0] wdata,
    output logic [7:0] reg_a_rd,
    output logic [7:0] reg_b_rd,
    output logic       sqw,
    output logic       pf,
    output logic       irq
);

    logic [2:0]         div_q;
    logic [3:0]         rate_q;
    logic               pie_q;
    logic               sqwe_q;
    chain_mode_e        mode;
    logic [CHAIN_W-1:0] chain_cnt;
    logic               tap;
    logic               rise_evt;
    logic               advance;

    // Rate/divider register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_RST;
            rate_q <= RATE_RST;
        end else if (wr_a) begin
            div_q  <= wdata[6:4];
            rate_q <= wdata[3:0];
        end
    end

    // Enable register load: periodic enable and square-wave enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pie_q  <= 1'b0;
            sqwe_q <= 1'b0;
        end else if (wr_b) begin
            pie_q  <= wdata[6];
            sqwe_q <= wdata[3];
        end
    end

    // Mode decode and advance qualifier for the edge detector.
    always_comb begin
        mode    = decode_div(div_q);
        advance = tb_tick & (mode == CHAIN_RUN);
    end

    rtg_prescaler #(.CHAIN_W(CHAIN_W)) i_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tb_tick),
        .mode  (mode),
        .cnt   (chain_cnt)
    );

    rtg_rate_tap #(.CHAIN_W(CHAIN_W)) i_rate_tap (
        .cnt      (chain_cnt),
        .rate_sel (rate_q),
        .advance  (advance),
        .tap      (tap),
        .rise_evt (rise_evt)
    );

    rtg_flag i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (rise_evt),
        .clr_rd  (rd_c),
        .flag    (pf)
    );

    // Output gating and register read views.
    always_comb begin
        sqw      = sqwe_q & tap;
        irq      = pf & pie_q;
        reg_a_rd = {1'b0, div_q, rate_q};
        reg_b_rd = {1'b0, pie_q, 2'b00, sqwe_q, 3'b000};
    end

endmodule

// File: rtl/rtg_checker.sv
// Module: rtg_checker
// Temporal properties of the periodic rate generator, bound to its top.
module rtg_checker #(
    parameter int unsigned CHAIN_W = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_c,
    input logic [2:0]         div_q,
    input logic [3:0]         rate_q,
    input logic [CHAIN_W-1:0] chain_cnt,
    input logic               rise_evt,
    input logic               pf,
    input logic               sqw,
    input logic               irq
);

    // R4: an event always leaves the flag set.
    p_set_after_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> pf);

    // R4: the request never appears without the flag.
    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pf);

    // R5: without a read, a set flag stays set.
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pf && !rd_c) |=> pf);

    // R5: a read with no coincident event clears the flag.
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !rise_evt) |=> !pf);

    // R6: rate zero gives no event and a low pin.
    p_rate_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q == 4'd0) |-> (!rise_evt && !sqw));

    // R7: clear modes drive the chain to zero.
    p_clear_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q[2:1] == 2'b11) |=> (chain_cnt == '0));

    // R8: hold modes freeze the chain.
    p_hold_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != 3'b010 && div_q[2:1] != 2'b11) |=> $stable(chain_cnt));

endmodule

bind periodic_rate_gen rtg_checker #(.CHAIN_W(CHAIN_W)) i_rtg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_c      (rd_c),
    .div_q     (div_q),
    .rate_q    (rate_q),
    .chain_cnt (chain_cnt),
    .rise_evt  (rise_evt),
    .pf        (pf),
    .sqw       (sqw),
    .irq       (irq)
);

// File: tb/test_periodic_rate_gen.sv
`timescale 1ns/100ps
module test_periodic_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tb_tick, wr_a, wr_b, rd_c;
    logic [7:0] wdata;
    logic [7:0] reg_a_rd, reg_b_rd;
    logic       sqw, pf, irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Behavioural model state
    int         m_cnt;
    logic [2:0] m_dv;
    logic [3:0] m_rs;
    logic       m_pie, m_sqwe, m_pf;

    always #2.5 clk = ~clk;

    periodic_rate_gen i_periodic_rate_gen (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .wr_a(wr_a), .wr_b(wr_b),
        .rd_c(rd_c), .wdata(wdata), .reg_a_rd(reg_a_rd), .reg_b_rd(reg_b_rd),
        .sqw(sqw), .pf(pf), .irq(irq)
    );

    // Half period in pulses of the selected stage, from the rate rules.
    function automatic int half_period(input logic [3:0] rs);
        if (rs == 4'd1) return 64;
        if (rs == 4'd2) return 128;
        return 1 << (int'(rs) - 2);
    endfunction

    function automatic logic exp_sqw();
        if (!m_sqwe || m_rs == 4'd0) return 1'b0;
        return ((m_cnt / half_period(m_rs)) % 2) == 1;
    endfunction

    task automatic compare(input string tag);
        logic       e_sqw, e_irq;
        logic [7:0] e_a, e_b;
        e_sqw = exp_sqw();
        e_irq = m_pf & m_pie;
        e_a   = {1'b0, m_dv, m_rs};
        e_b   = {1'b0, m_pie, 2'b00, m_sqwe, 3'b000};
        vectors++;
        if (sqw !== e_sqw || pf !== m_pf || irq !== e_irq ||
            reg_a_rd !== e_a || reg_b_rd !== e_b) begin
            errors++;
            $display("FAIL %s: sqw=%b/%b pf=%b/%b irq=%b/%b a=%h/%h b=%h/%h (actual/expected)",
                     tag, sqw, e_sqw, pf, m_pf, irq, e_irq, reg_a_rd, e_a, reg_b_rd, e_b);
        end
    endtask

    // One clock: apply inputs, advance the model, compare after the edge.
    task automatic step(input bit tk, input bit wa, input bit wb, input bit rc,
                        input logic [7:0] d, input string tag);
        bit ev;
        int nxt;
        tb_tick = tk; wr_a = wa; wr_b = wb; rd_c = rc; wdata = d;
        @(posedge clk);
        #1;
        ev  = 1'b0;
        nxt = (m_cnt + 1) % 16384;
        if (m_dv == 3'b010 && tk && m_rs != 4'd0)
            ev = (nxt % (2 * half_period(m_rs))) == half_period(m_rs);
        if (m_dv[2:1] == 2'b11)  m_cnt = 0;
        else if (m_dv == 3'b010 && tk) m_cnt = nxt;
        if (ev)      m_pf = 1'b1;
        else if (rc) m_pf = 1'b0;
        if (wa) begin m_dv = d[6:4]; m_rs = d[3:0]; end
        if (wb) begin m_pie = d[6]; m_sqwe = d[3]; end
        compare(tag);
        tb_tick = 1'b0; wr_a = 1'b0; wr_b = 1'b0; rd_c = 1'b0;
    endtask

    // R2/R5: measure cycles between flag events while reading every cycle.
    task automatic measure(input logic [3:0] rs, input int expect_gap);
        int last, gap, seen;
        step(0, 1, 0, 0, {1'b0, 3'b110, rs}, "R7");
        step(0, 1, 0, 0, {1'b0, 3'b010, rs}, "R2");
        last = -1; gap = 0; seen = 0;
        for (int c = 0; c < 3 * expect_gap + 4; c++) begin
            step(1, 0, 0, 1, 8'h00, "R5");
            if (pf) begin
                if (last >= 0 && seen == 1) gap = c - last;
                last = c;
                seen++;
            end
        end
        vectors++;
        if (gap != expect_gap) begin
            errors++;
            $display("FAIL R2: rate %0d gap=%0d expected=%0d", rs, gap, expect_gap);
        end
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; tb_tick = 0; wr_a = 0; wr_b = 0; rd_c = 0; wdata = 8'h00;
        m_cnt = 0; m_dv = 3'b010; m_rs = 4'b0110; m_pie = 0; m_sqwe = 0; m_pf = 0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1");                       // R1 reset state
        rst_n = 1'b1;

        // R2 run with defaults, R3 square wave enabled then disabled
        step(0, 0, 1, 0, 8'h08, "R3");
        for (int i = 0; i < 80; i++) step(1, 0, 0, 0, 8'h00, "R3");
        step(0, 0, 1, 0, 8'h40, "R4");       // periodic enable only
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 8'h00, "R4");
        step(0, 0, 0, 1, 8'h00, "R5");

        // R2 periods for fast and slow taps, R5 read coinciding with set
        measure(4'd3, 4);
        measure(4'd4, 8);
        measure(4'd6, 32);
        measure(4'd1, 128);
        measure(4'd2, 256);

        // R6 rate zero
        step(0, 0, 1, 0, 8'h48, "R6");
        step(0, 1, 0, 1, 8'h20, "R6");
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 8'h00, "R6");

        // R8 freeze mid-period with the pin high
        step(0, 1, 0, 0, 8'h25, "R8");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 8'h00, "R8");
        step(0, 1, 0, 1, 8'h05, "R8");
        for (int i = 0; i < 50; i++) step(1, 0, 0, 0, 8'h00, "R8");

        // R7 clear mode, then restart
        step(0, 1, 0, 0, 8'h73, "R7");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 8'h00, "R7");
        step(0, 1, 0, 0, 8'h23, "R7");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 8'h00, "R7");

        // R9 unused bits
        step(0, 0, 1, 0, 8'hFF, "R9");
        step(0, 1, 0, 0, 8'hFF, "R9");
        step(0, 0, 1, 0, 8'hB7, "R9");
        step(0, 1, 0, 0, 8'hA4, "R9");

        // Random mix
        for (int i = 0; i < 30000; i++) begin
            bit tk, wa, wb, rc;
            logic [7:0] d;
            logic [2:0] dv;
            tk = ($urandom % 2) == 0;
            wa = ($urandom % 97) == 0;
            wb = ($urandom % 61) == 0;
            rc = ($urandom % 9) == 0;
            dv = (($urandom % 5) != 0) ? 3'b010 : 3'($urandom);
            d  = wa ? {1'b0, dv, 4'($urandom % 9)} : 8'($urandom);
            step(tk, wa, wb, rc, d, "R4");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule